// File: doc/BRIEF.md
# Serial Configuration Word Receiver

This block takes 48-bit configuration words from a three-wire serial port (data, clock and an active-low frame strobe) and turns them into the settings of an image-sensor timing generator. A word is only believed when its leading byte carries the expected chip identity and, unless checking is switched off, when its six bytes sum to zero modulo 256. A two-bit category field then steers the payload into either a control bank or a shutter bank.

Accepted words first land in a shadow copy with a pending flag. The live outputs pick them up at the moment each field is meant to change. Standby is applied as soon as the strobe returns high. Shutter mode, converter clock phase and the three shutter counts wait for the next horizontal sync falling edge. Drive mode and sensor select wait for the next vertical sync falling edge. While a long exposure is running, an external hold input makes the block refuse new words.

The serial pins are asynchronous and are brought into the system clock domain through a chain of flip-flops. The sync inputs are taken as already synchronous to the system clock.

Top module: `serial_ctl_rx`

## Requirements
- R1: After reset every output is zero, except `adc_phase`, which is 2'b01.
- R2: While `ser_stb_n` is low, `ser_dat` is captured on each rising edge of `ser_clk`, with the first bit as D00. A word is evaluated when `ser_stb_n` rises.
- R3: A strobe window with a number of serial clocks other than 48 is discarded, and no output or shadow changes.
- R4: A word whose bits D07..D00 differ from 8'h81 (D00 and D07 are 1, the rest 0) is discarded.
- R5: When `csum_off` is low, a word is discarded unless the byte sum (D07..D00)+(D15..D08)+...+(D47..D40) is 0 modulo 256. When `csum_off` is high, the sum is not checked.
- R6: Category D09..D08 = 00 selects the control bank and 01 selects the shutter bank. A word with 10 or 11 changes nothing.
- R7: An accepted control word sets `stby_mode` right after the strobe rises, from D39..D38. If D38 is 0 the result is 00 (normal). D39..D38 = 01 gives 01 (sleep), and 11 gives 11 (standby).
- R8: Shutter mode (D14..D13) and ADC clock phase (D37..D36) from a pending control word reach `shut_mode` and `adc_phase` at the next falling edge of `hsync`.
- R9: Drive mode (D11..D10) and sensor select (D12) from a pending control word reach `drv_mode` and `sensor_sel` at the next falling edge of `vsync`, and at no other time.
- R10: A pending shutter word delivers `svd` = D17..D10, `shd` = D27..D18 and `spl` = D35..D28 at the next falling edge of `hsync`.
- R11: A word whose strobe rises while `expo_hold` is high is discarded.
- R12: A second word of the same category that arrives before the commit replaces the first. Each pending flag clears when its commit happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat | input | 1 | Serial data, asynchronous |
| ser_clk | input | 1 | Serial clock, asynchronous |
| ser_stb_n | input | 1 | Frame strobe, low during a transfer |
| csum_off | input | 1 | High skips the checksum test |
| hsync | input | 1 | Horizontal sync, falling edge commits line fields |
| vsync | input | 1 | Vertical sync, falling edge commits frame fields |
| expo_hold | input | 1 | High refuses new words |
| drv_mode | output | 2 | Active drive mode |
| sensor_sel | output | 1 | Active sensor select |
| shut_mode | output | 2 | Active shutter mode |
| adc_phase | output | 2 | Active converter clock phase |
| stby_mode | output | 2 | Active standby state |
| svd | output | 8 | Shutter vertical count |
| shd | output | 10 | Shutter horizontal count |
| spl | output | 8 | Shutter vertical position |

## Verification
The bench builds the receiver with a three-stage synchronizer and the default identity byte 8'h81. The deeper synchronizer shows that word evaluation and the standby update depend only on strobe and clock edges, and not on a fixed latency. Random words mix categories, corrupted identity bytes, broken checksums with the check on and off, 47- and 49-clock windows, and the exposure hold. Separate horizontal and vertical pulses after each word show which fields move at which edge.

// File: rtl/serial_ctl_rx.sv
module serial_ctl_rx #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] CHIP_ID     = 8'h81
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_dat,
  input  logic       ser_clk,
  input  logic       ser_stb_n,
  input  logic       csum_off,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       expo_hold,
  output logic [1:0] drv_mode,
  output logic       sensor_sel,
  output logic [1:0] shut_mode,
  output logic [1:0] adc_phase,
  output logic [1:0] stby_mode,
  output logic [7:0] svd,
  output logic [9:0] shd,
  output logic [7:0] spl
);
  localparam int WBITS = 48;
  localparam int CW    = $clog2(WBITS + 2);
  localparam logic [CW-1:0] FULL = CW'(WBITS);
  localparam logic [CW-1:0] OVER = CW'(WBITS + 1);

  logic [SYNC_STAGES-1:0] sd, sc, ss;
  logic sc_q, ss_q, hs_q, vs_q;
  logic [WBITS-1:0] sr;
  logic [CW-1:0]    cnt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sd <= '0; sc <= '0; ss <= '1;
      sc_q <= 1'b0; ss_q <= 1'b1; hs_q <= 1'b1; vs_q <= 1'b1;
    end else begin
      sd <= {sd[SYNC_STAGES-2:0], ser_dat};
      sc <= {sc[SYNC_STAGES-2:0], ser_clk};
      ss <= {ss[SYNC_STAGES-2:0], ser_stb_n};
      sc_q <= sc[SYNC_STAGES-1];
      ss_q <= ss[SYNC_STAGES-1];
      hs_q <= hsync;
      vs_q <= vsync;
    end

  wire s_dat    = sd[SYNC_STAGES-1];
  wire sclk_up  = sc[SYNC_STAGES-1] & ~sc_q;
  wire in_frame = ~ss[SYNC_STAGES-1];
  wire stb_rise = ss[SYNC_STAGES-1] & ~ss_q;
  wire h_fall   = hs_q & ~hsync;
  wire v_fall   = vs_q & ~vsync;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (stb_rise) begin
      cnt <= '0;
    end else if (in_frame && sclk_up) begin
      sr  <= {s_dat, sr[WBITS-1:1]};
      cnt <= (cnt == OVER) ? OVER : cnt + CW'(1);
    end

  logic [7:0] tot;
  assign tot = sr[7:0] + sr[15:8] + sr[23:16] + sr[31:24] + sr[39:32] + sr[47:40];

  wire word_ok = stb_rise && (cnt == FULL) && (sr[7:0] == CHIP_ID)
                 && (csum_off || tot == 8'd0) && !expo_hold;
  wire acc_ctl = word_ok && (sr[9:8] == 2'b00);
  wire acc_sh  = word_ok && (sr[9:8] == 2'b01);

  logic [1:0] c_drv, c_smd, c_adc;
  logic       c_sen, pend_h, pend_v, pend_s;
  logic [7:0] s_svd, s_spl;
  logic [9:0] s_shd;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      c_drv <= '0; c_sen <= 1'b0; c_smd <= '0; c_adc <= 2'b01;
      s_svd <= '0; s_shd <= '0; s_spl <= '0;
      pend_h <= 1'b0; pend_v <= 1'b0; pend_s <= 1'b0;
    end else begin
      if (acc_ctl) begin
        c_drv <= sr[11:10];
        c_sen <= sr[12];
        c_smd <= sr[14:13];
        c_adc <= sr[37:36];
      end
      if (acc_sh) begin
        s_svd <= sr[17:10];
        s_shd <= sr[27:18];
        s_spl <= sr[35:28];
      end
      if (acc_ctl)     pend_h <= 1'b1;
      else if (h_fall) pend_h <= 1'b0;
      if (acc_ctl)     pend_v <= 1'b1;
      else if (v_fall) pend_v <= 1'b0;
      if (acc_sh)      pend_s <= 1'b1;
      else if (h_fall) pend_s <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      drv_mode <= '0; sensor_sel <= 1'b0; shut_mode <= '0; adc_phase <= 2'b01;
      stby_mode <= '0; svd <= '0; shd <= '0; spl <= '0;
    end else begin
      if (acc_ctl) stby_mode <= sr[38] ? {sr[39], 1'b1} : 2'b00;
      if (v_fall && pend_v) begin
        drv_mode   <= c_drv;
        sensor_sel <= c_sen;
      end
      if (h_fall && pend_h) begin
        shut_mode <= c_smd;
        adc_phase <= c_adc;
      end
      if (h_fall && pend_s) begin
        svd <= s_svd;
        shd <= s_shd;
        spl <= s_spl;
      end
    end

  // R9
  drv_at_vsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({drv_mode, sensor_sel}) |-> $past(v_fall));
  // R8
  line_ctl_at_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({shut_mode, adc_phase}) |-> $past(h_fall));
  // R10
  shutter_at_hsync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({svd, shd, spl}) |-> $past(h_fall));
  // R7
  stby_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(stby_mode) |-> $past(acc_ctl));
  // R12
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_fall && pend_s && !acc_sh) |=> !pend_s);
  // R3
  count_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb_rise |=> (cnt == '0));
endmodule

// File: tb/sim_serial_ctl_rx.sv
module sim_serial_ctl_rx;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_dat = 1'b0, ser_clk = 1'b0, ser_stb_n = 1'b1;
  logic csum_off = 1'b0, hsync = 1'b1, vsync = 1'b1, expo_hold = 1'b0;
  logic [1:0] drv_mode, shut_mode, adc_phase, stby_mode;
  logic sensor_sel;
  logic [7:0] svd, spl;
  logic [9:0] shd;

  always #2 clk = ~clk;

  serial_ctl_rx #(.SYNC_STAGES(3), .CHIP_ID(8'h81)) u0 (
    .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk(ser_clk),
    .ser_stb_n(ser_stb_n), .csum_off(csum_off), .hsync(hsync), .vsync(vsync),
    .expo_hold(expo_hold), .drv_mode(drv_mode), .sensor_sel(sensor_sel),
    .shut_mode(shut_mode), .adc_phase(adc_phase), .stby_mode(stby_mode),
    .svd(svd), .shd(shd), .spl(spl));

  int n_cmp = 0, n_bad = 0;
  logic [1:0] e_drv = 0, e_smd = 0, e_adc = 2'b01, e_stby = 0;
  logic e_sen = 0;
  logic [7:0] e_svd = 0, e_spl = 0;
  logic [9:0] e_shd = 0;
  logic [1:0] m_drv = 0, m_smd = 0, m_adc = 2'b01;
  logic m_sen = 0;
  logic [7:0] m_svd = 0, m_spl = 0;
  logic [9:0] m_shd = 0;
  logic p_h = 0, p_v = 0, p_s = 0;

  function automatic logic [7:0] bsum(input logic [47:0] w);
    logic [7:0] s = 0;
    for (int i = 0; i < 6; i++) s = s + w[8*i +: 8];
    return s;
  endfunction

  function automatic logic [47:0] mk(input logic [1:0] cat, input logic [29:0] body);
    logic [47:0] w;
    w = {8'h00, body, cat, 8'h81};
    w[47:40] = 8'h00 - bsum(w);
    return w;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    cmp("R9", {ctx, " drv_mode"}, drv_mode, e_drv);
    cmp("R9", {ctx, " sensor_sel"}, sensor_sel, e_sen);
    cmp("R8", {ctx, " shut_mode"}, shut_mode, e_smd);
    cmp("R8", {ctx, " adc_phase"}, adc_phase, e_adc);
    cmp("R7", {ctx, " stby_mode"}, stby_mode, e_stby);
    cmp("R10", {ctx, " svd"}, svd, e_svd);
    cmp("R10", {ctx, " shd"}, shd, e_shd);
    cmp("R10", {ctx, " spl"}, spl, e_spl);
  endtask

  task automatic send(input logic [47:0] w, input int n);
    bit acc;
    ser_stb_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      ser_dat = (i < 48) ? w[i] : 1'b0;
      repeat (3) @(negedge clk);
      ser_clk = 1'b1;
      repeat (3) @(negedge clk);
      ser_clk = 1'b0;
    end
    repeat (3) @(negedge clk);
    ser_stb_n = 1'b1;
    repeat (12) @(negedge clk);
    acc = (n == 48) && (w[7:0] == 8'h81) && (csum_off || bsum(w) == 8'h00) && !expo_hold;
    if (acc && w[9:8] == 2'b00) begin
      m_drv = w[11:10]; m_sen = w[12]; m_smd = w[14:13]; m_adc = w[37:36];
      p_h = 1; p_v = 1;
      e_stby = w[38] ? {w[39], 1'b1} : 2'b00;
    end
    if (acc && w[9:8] == 2'b01) begin
      m_svd = w[17:10]; m_shd = w[27:18]; m_spl = w[35:28]; p_s = 1;
    end
  endtask

  task automatic hpulse();
    hsync = 1'b0; repeat (3) @(negedge clk);
    hsync = 1'b1; repeat (3) @(negedge clk);
    if (p_h) begin e_smd = m_smd; e_adc = m_adc; p_h = 0; end
    if (p_s) begin e_svd = m_svd; e_shd = m_shd; e_spl = m_spl; p_s = 0; end
  endtask

  task automatic vpulse();
    vsync = 1'b0; repeat (3) @(negedge clk);
    vsync = 1'b1; repeat (3) @(negedge clk);
    if (p_v) begin e_drv = m_drv; e_sen = m_sen; p_v = 0; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [47:0] w;
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    check_all("R1 reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R1 after release");

    // R2 plain control word with standby 11, drive 01, sensor 1, smd 10, phase 11
    w = mk(2'b00, {2'b11, 2'b11, 21'h0, 2'b10, 1'b1, 2'b01});
    send(w, 48);
    check_all("R2 ctl before sync");
    hpulse(); check_all("R8 after hsync");
    vpulse(); check_all("R9 after vsync");

    // R3 wrong clock counts
    w = mk(2'b00, {2'b01, 2'b00, 21'h0, 2'b01, 1'b0, 2'b10});
    send(w, 47); hpulse(); vpulse(); check_all("R3 47 clocks");
    send(w, 49); hpulse(); vpulse(); check_all("R3 49 clocks");

    // R4 wrong chip byte
    w[0] = 1'b0; w[47:40] = w[47:40] + 8'd1;
    send(w, 48); hpulse(); vpulse(); check_all("R4 chip byte");

    // R5 broken sum rejected, then accepted with check off
    w = mk(2'b01, {8'h12, 10'h2A5, 8'h3C, 4'h0}) ^ 48'h0100_0000_0000;
    send(w, 48); hpulse(); check_all("R5 bad sum");
    csum_off = 1'b1;
    send(w, 48); hpulse(); check_all("R5 sum off");
    csum_off = 1'b0;

    // R6 test category touches nothing
    w = mk(2'b10, {2'b11, 2'b00, 30'h0} >> 4);
    send(w, 48); check_all("R6 test cat"); hpulse(); vpulse(); check_all("R6 test cat sync");

    // R11 hold
    expo_hold = 1'b1;
    w = mk(2'b01, {8'hFF, 10'h3FF, 8'hFF, 4'h0});
    send(w, 48);
    expo_hold = 1'b0;
    hpulse(); check_all("R11 hold");

    // R12 overwrite before commit
    send(mk(2'b01, {8'h11, 10'h111, 8'h11, 4'h0}), 48);
    send(mk(2'b01, {8'h22, 10'h222, 8'h22, 4'h0}), 48);
    hpulse(); check_all("R12 overwrite");
    hpulse(); check_all("R12 no recommit");

    for (int it = 0; it < 60; it++) begin
      int r, n;
      logic [1:0] cat;
      r = $urandom;
      cat = ($urandom % 5 == 0) ? 2'b10 + 2'($urandom % 2) : 2'($urandom % 2);
      w = mk(cat, 30'($urandom));
      n = 48;
      case (r % 10)
        0: w[7:0] = w[7:0] ^ 8'(1 << ($urandom % 8));
        1: w[47:40] = w[47:40] + 8'd3;
        2: n = 47;
        3: n = 49;
        default: ;
      endcase
      csum_off = ($urandom % 4 == 0);
      expo_hold = ($urandom % 8 == 0);
      send(w, n);
      expo_hold = 1'b0;
      check_all("R2 random word");
      if ($urandom % 2) begin hpulse(); check_all("R8 random hsync"); end
      if ($urandom % 2) begin vpulse(); check_all("R9 random vsync"); end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule